// File: doc/BRIEF.md
# Serial Pin Software Override

This block sits between a serial controller and its five pads: transmit data, receive data, serial clock, and two flow-control lines. While the serial function that owns a pin is switched off, software can take that pin over as a plain port. It drives the pin from a data bit when the matching direction bit selects output, and it releases the pad when the direction bit selects input. Pulling the transmit line low in this way produces a break condition on the link.

While the serial function is on, the controller's own drive and output enable reach the pad, and the software bits are ignored. Every pad level is brought back through a two-flop synchronizer in every mode, including while the pad is being driven. Software can therefore watch the receive line for a break, and read back the clock and flow-control lines, at any time.

Pin indices are fixed across all vectors: 0 is transmit data, 1 is receive data, 2 is serial clock, 3 and 4 are the two flow-control lines. A direction bit of 1 means output.

Top module: `serial_pin_override`

## Requirements
- R1: With `ctl_tx_en` low and `sw_dir[0]` = 1, `pad_oe[0]` is 1 and `pad_out[0]` equals `sw_data[0]` in the same cycle. Holding `sw_data[0]` at 0 sends a break.
- R2: With `ctl_tx_en` high, `pad_out[0]` and `pad_oe[0]` equal `ctl_out[0]` and `ctl_oe[0]`. `sw_data`, `sw_dir` and `ctl_rx_en` have no effect on pin 0.
- R3: For pins 2, 3 and 4, the serial function counts as on when `ctl_tx_en` or `ctl_rx_en` is high. While it is on, `pad_out` and `pad_oe` of these pins equal `ctl_out` and `ctl_oe`. While it is off, they follow the software bits as in R1.
- R4: On a drivable pin (0, 2, 3 or 4) in software mode with its direction bit at 0, `pad_oe` is 0 and `pad_out` is 0. Each pin's direction bit acts on that pin alone.
- R5: Pin 1 (receive data) is never driven: `pad_oe[1]` and `pad_out[1]` are 0 in every mode, whatever the controller or software bits say.
- R6: After reset, `pin_level[i]` equals the value `pad_in[i]` had two clock edges earlier, for every pin and in every mode.
- R7: While `rst` is high, and at the first cycle after it, `pin_level` reads all ones (idle line).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctl_tx_en | input | 1 | Serial transmitter enabled |
| ctl_rx_en | input | 1 | Serial receiver enabled |
| ctl_out | input | 5 | Controller drive value per pin |
| ctl_oe | input | 5 | Controller output enable per pin |
| sw_data | input | 5 | Software port data bits |
| sw_dir | input | 5 | Software direction bits, 1 = output |
| pad_in | input | 5 | Pad input levels |
| pad_out | output | 5 | Muxed pad drive value |
| pad_oe | output | 5 | Muxed pad output enable |
| pin_level | output | 5 | Synchronized pad levels for software |

## Verification
The mux is exercised with the controller bits set opposite to the software bits. Any pad value therefore shows which owner was chosen. Each enable combination is tried (transmit only, receive only, both, neither), which tells apart pin 0, gated by the transmitter alone, from the auxiliary pins, gated by either enable. Mixed direction patterns with all-ones data separate a released pin from a driven-low one, and also reveal any pin-to-pin coupling. Walking and held-low pad patterns, including a long low on receive data, pin down the two-cycle readback delay and the idle value that reset restores.

// File: rtl/spo_pkg.sv
package spo_pkg;

    localparam int NUM_PINS   = 5;
    localparam int IDX_TXD    = 0;
    localparam int IDX_RXD    = 1;
    localparam int IDX_SCK    = 2;
    localparam int IDX_FLOW_A = 3;
    localparam int IDX_FLOW_B = 4;
    localparam int SYNC_DEPTH = 2;

    localparam logic [NUM_PINS-1:0] LEVEL_IDLE = '1;

    // Which enable gates a pin's software takeover
    typedef enum logic [1:0] {
        ROLE_TX  = 2'd0,
        ROLE_RX  = 2'd1,
        ROLE_AUX = 2'd2
    } pin_role_e;

    // Who currently owns a pad
    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_SW   = 2'd1,
        OWN_CTL  = 2'd2
    } owner_e;

    typedef struct packed {
        logic level;
        logic enable;
    } drive_t;

    function automatic pin_role_e role_of(input int idx);
        if (idx == IDX_TXD)      return ROLE_TX;
        else if (idx == IDX_RXD) return ROLE_RX;
        else                     return ROLE_AUX;
    endfunction

    function automatic owner_e pick_owner(input pin_role_e role,
                                          input logic tx_en,
                                          input logic rx_en,
                                          input logic dir_out);
        logic func_on;
        case (role)
            ROLE_TX:  func_on = tx_en;
            ROLE_AUX: func_on = tx_en | rx_en;
            default:  func_on = 1'b0;
        endcase
        if (role == ROLE_RX) return OWN_NONE;
        else if (func_on)    return OWN_CTL;
        else if (dir_out)    return OWN_SW;
        else                 return OWN_NONE;
    endfunction

endpackage

// File: rtl/spo_owner_sel.sv
module spo_owner_sel
    import spo_pkg::*;
#(
    parameter pin_role_e ROLE = ROLE_AUX
) (
    input  logic   tx_en,
    input  logic   rx_en,
    input  logic   dir_out,
    output owner_e owner
);

    always_comb begin
        owner = pick_owner(ROLE, tx_en, rx_en, dir_out);
    end

endmodule

// File: rtl/spo_pin_mux.sv
module spo_pin_mux
    import spo_pkg::*;
(
    input  owner_e owner,
    input  drive_t ctl_drv,
    input  logic   sw_bit,
    output drive_t pad_drv
);

    always_comb begin
        case (owner)
            OWN_CTL: pad_drv = ctl_drv;
            OWN_SW:  pad_drv = '{level: sw_bit, enable: 1'b1};
            default: pad_drv = '{level: 1'b0, enable: 1'b0};
        endcase
    end

endmodule

// File: rtl/spo_sync.sv
module spo_sync #(
    parameter int                WIDTH     = 5,
    parameter int                STAGES    = 2,
    parameter logic [WIDTH-1:0]  RESET_VAL = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= RESET_VAL;
        end else begin
            stage_q[0] <= d;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/serial_pin_override.sv
module serial_pin_override
    import spo_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                ctl_tx_en,
    input  logic                ctl_rx_en,
    input  logic [NUM_PINS-1:0] ctl_out,
    input  logic [NUM_PINS-1:0] ctl_oe,
    input  logic [NUM_PINS-1:0] sw_data,
    input  logic [NUM_PINS-1:0] sw_dir,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] pin_level
);

    // Per-pin ownership decision and output mux (R1-R5)
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        owner_e owner_w;
        drive_t ctl_w;
        drive_t pad_w;

        assign ctl_w = '{level: ctl_out[i], enable: ctl_oe[i]};

        spo_owner_sel #(
            .ROLE (role_of(i))
        ) u_sel (
            .tx_en   (ctl_tx_en),
            .rx_en   (ctl_rx_en),
            .dir_out (sw_dir[i]),
            .owner   (owner_w)
        );

        spo_pin_mux u_mux (
            .owner   (owner_w),
            .ctl_drv (ctl_w),
            .sw_bit  (sw_data[i]),
            .pad_drv (pad_w)
        );

        assign pad_out[i] = pad_w.level;
        assign pad_oe[i]  = pad_w.enable;
    end

    // Readback in every mode (R6, R7)
    spo_sync #(
        .WIDTH     (NUM_PINS),
        .STAGES    (SYNC_DEPTH),
        .RESET_VAL (LEVEL_IDLE)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (pin_level)
    );

endmodule

// File: rtl/serial_pin_override_chk.sv
module serial_pin_override_chk
    import spo_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                ctl_tx_en,
    input logic                ctl_rx_en,
    input logic [NUM_PINS-1:0] ctl_out,
    input logic [NUM_PINS-1:0] ctl_oe,
    input logic [NUM_PINS-1:0] sw_data,
    input logic [NUM_PINS-1:0] sw_dir,
    input logic [NUM_PINS-1:0] pad_in,
    input logic [NUM_PINS-1:0] pad_out,
    input logic [NUM_PINS-1:0] pad_oe,
    input logic [NUM_PINS-1:0] pin_level
);

    logic [1:0] run_cnt;
    logic       aux_on;

    assign aux_on = ctl_tx_en | ctl_rx_en;

    always_ff @(posedge clk) begin
        if (rst)                 run_cnt <= 2'd0;
        else if (run_cnt != 2'd3) run_cnt <= run_cnt + 2'd1;
    end

    assert_sw_tx_R1: assert property (@(posedge clk) disable iff (rst)
        (!ctl_tx_en && sw_dir[0]) |-> (pad_oe[0] && pad_out[0] == sw_data[0]));

    assert_ctl_tx_R2: assert property (@(posedge clk) disable iff (rst)
        ctl_tx_en |-> (pad_oe[0] == ctl_oe[0] && pad_out[0] == ctl_out[0]));

    assert_ctl_aux_R3: assert property (@(posedge clk) disable iff (rst)
        aux_on |-> (pad_oe[4:2] == ctl_oe[4:2] && pad_out[4:2] == ctl_out[4:2]));

    assert_sw_aux_R3: assert property (@(posedge clk) disable iff (rst)
        !aux_on |-> (pad_oe[4:2] == sw_dir[4:2] &&
                     pad_out[4:2] == (sw_data[4:2] & sw_dir[4:2])));

    assert_release_R4: assert property (@(posedge clk) disable iff (rst)
        (!ctl_tx_en && !sw_dir[0]) |-> (!pad_oe[0] && !pad_out[0]));

    assert_rx_ctl_R5: assert property (@(posedge clk) disable iff (rst)
        (ctl_oe[1] || ctl_out[1]) |-> (!pad_oe[1] && !pad_out[1]));

    assert_rx_sw_R5: assert property (@(posedge clk) disable iff (rst)
        (sw_dir[1] || sw_data[1]) |-> (!pad_oe[1] && !pad_out[1]));

    assert_delay_R6: assert property (@(posedge clk) disable iff (rst)
        (run_cnt >= 2'd2) |-> (pin_level == $past(pad_in, 2)));

    assert_idle_R7: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pin_level == LEVEL_IDLE));

endmodule

bind serial_pin_override serial_pin_override_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .ctl_tx_en (ctl_tx_en),
    .ctl_rx_en (ctl_rx_en),
    .ctl_out   (ctl_out),
    .ctl_oe    (ctl_oe),
    .sw_data   (sw_data),
    .sw_dir    (sw_dir),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .pin_level (pin_level)
);

// File: tb/sim_serial_pin_override.sv
module sim_serial_pin_override;

    logic       clk = 1'b0;
    logic       rst;
    logic       ctl_tx_en, ctl_rx_en;
    logic [4:0] ctl_out, ctl_oe, sw_data, sw_dir, pad_in;
    logic [4:0] pad_out, pad_oe, pin_level;

    always #2 clk = ~clk;   // 250 MHz

    serial_pin_override u0 (
        .clk       (clk),
        .rst       (rst),
        .ctl_tx_en (ctl_tx_en),
        .ctl_rx_en (ctl_rx_en),
        .ctl_out   (ctl_out),
        .ctl_oe    (ctl_oe),
        .sw_data   (sw_data),
        .sw_dir    (sw_dir),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .pin_level (pin_level)
    );

    typedef struct {
        logic [4:0] out;
        logic [4:0] oe;
        logic [4:0] lvl;
        string      tag;
    } exp_t;

    exp_t       sbq[$];
    int         checks = 0;
    int         fails  = 0;
    logic [4:0] prev_pad;
    logic       done = 1'b0;

    task automatic chk(input string req, input logic [4:0] got, input logic [4:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    // Expected pad drive from the requirements (R1-R5)
    function automatic void model(input logic tx, input logic rx,
                                  input logic [4:0] co, input logic [4:0] coe,
                                  input logic [4:0] sd, input logic [4:0] sdir,
                                  output logic [4:0] eo, output logic [4:0] eoe);
        for (int i = 0; i < 5; i++) begin
            logic fn;
            fn = (i == 0) ? tx : (tx | rx);
            if (i == 1) begin
                eo[i] = 1'b0; eoe[i] = 1'b0;
            end else if (fn) begin
                eo[i] = co[i]; eoe[i] = coe[i];
            end else begin
                eo[i] = sd[i] & sdir[i]; eoe[i] = sdir[i];
            end
        end
    endfunction

    // Driver: one call per cycle, back to back
    task automatic drive(input logic tx, input logic rx,
                         input logic [4:0] co, input logic [4:0] coe,
                         input logic [4:0] sd, input logic [4:0] sdir,
                         input logic [4:0] pin, input string tag);
        exp_t e;
        @(negedge clk);
        rst = 1'b0;
        ctl_tx_en = tx; ctl_rx_en = rx;
        ctl_out = co; ctl_oe = coe; sw_data = sd; sw_dir = sdir; pad_in = pin;
        model(tx, rx, co, coe, sd, sdir, e.out, e.oe);
        e.lvl = prev_pad;
        e.tag = tag;
        sbq.push_back(e);
        prev_pad = pin;
    endtask

    // Monitor: compare after each rising edge
    always @(posedge clk) begin
        #1;
        while (sbq.size() > 0) begin
            exp_t e;
            e = sbq.pop_front();
            chk({e.tag, " pad_out"}, pad_out, e.out);
            chk({e.tag, " pad_oe"}, pad_oe, e.oe);
            chk({"R6 pin_level / ", e.tag}, pin_level, e.lvl);
        end
    end

    task automatic reset_seq();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        chk("R7 pin_level in reset", pin_level, 5'b11111);
        prev_pad = 5'b11111;
    endtask

    initial begin
        rst = 1'b1;
        ctl_tx_en = 1'b0; ctl_rx_en = 1'b0;
        ctl_out = '0; ctl_oe = '0; sw_data = '0; sw_dir = '0; pad_in = '0;
        prev_pad = 5'b11111;
        reset_seq();

        // R1: software break on transmit data, then release to mark
        drive(0, 0, 5'b11111, 5'b11111, 5'b00000, 5'b00001, 5'b00000, "R1 break");
        drive(0, 0, 5'b11111, 5'b11111, 5'b00000, 5'b00001, 5'b00000, "R1 break hold");
        drive(0, 0, 5'b00000, 5'b00000, 5'b00001, 5'b00001, 5'b00001, "R1 mark");
        // R2: transmitter owns pin 0, software and rx enable ignored
        drive(1, 0, 5'b00001, 5'b00001, 5'b00000, 5'b00001, 5'b10101, "R2 ctl high");
        drive(1, 1, 5'b00000, 5'b00001, 5'b11111, 5'b00000, 5'b01010, "R2 ctl low");
        drive(1, 0, 5'b00000, 5'b00000, 5'b00001, 5'b00001, 5'b00100, "R2 ctl released");
        // R3: auxiliary pins under receiver only, transmitter only, neither
        drive(0, 1, 5'b01000, 5'b10100, 5'b10111, 5'b01011, 5'b11000, "R3 rx on");
        drive(1, 0, 5'b10100, 5'b01100, 5'b01011, 5'b10011, 5'b00011, "R3 tx on");
        drive(0, 0, 5'b11111, 5'b11111, 5'b01000, 5'b11100, 5'b11111, "R3 both off");
        // R4: mixed directions with all-ones data, per-pin independence
        drive(0, 0, 5'b11111, 5'b11111, 5'b11111, 5'b10100, 5'b00000, "R4 mix a");
        drive(0, 0, 5'b11111, 5'b11111, 5'b11111, 5'b01001, 5'b11111, "R4 mix b");
        drive(0, 0, 5'b00000, 5'b00000, 5'b11111, 5'b00000, 5'b00000, "R4 all input");
        // R5: receive data never driven in any mode
        drive(1, 1, 5'b11111, 5'b11111, 5'b11111, 5'b11111, 5'b11101, "R5 all ctl");
        drive(0, 0, 5'b11111, 5'b11111, 5'b11111, 5'b11111, 5'b11101, "R5 all sw");
        // R6: held-low receive line (break detect) and walking pad levels
        for (int k = 0; k < 6; k++)
            drive(0, 1, 5'b00000, 5'b00000, 5'b00000, 5'b00000, 5'b11101, "R6 rx break");
        for (int k = 0; k < 5; k++)
            drive(1, 1, 5'b00000, 5'b00000, 5'b00000, 5'b00000, 5'(1 << k), "R6 walk");
        drive(0, 0, 5'b00000, 5'b00000, 5'b00000, 5'b00000, 5'b00000, "R6 low");
        drive(0, 0, 5'b00000, 5'b00000, 5'b00000, 5'b00000, 5'b00000, "R6 low");
        // R7: reset restores idle readback after low pads
        reset_seq();
        drive(0, 0, 5'b00000, 5'b00000, 5'b00000, 5'b00000, 5'b00000, "R7 after reset");
        drive(0, 0, 5'b00000, 5'b00000, 5'b00000, 5'b00000, 5'b01010, "R7 resume");
        drive(0, 0, 5'b00000, 5'b00000, 5'b00000, 5'b00000, 5'b01010, "R7 resume");
        @(posedge clk);
        #2;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule